// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multicycle processor. It steps a small micro-address register through an internal store of sixteen-bit microinstructions. Each cycle it expands the compact fields of the current word into the individual enables and selects that the datapath needs. It also picks the next micro-address. That address is either the fetch step, the current address plus one, or an entry that an opcode lookup table returns for the instruction's six-bit opcode.

The microprogram covers fetch, decode and the execution paths for six instruction classes: register-register ALU, OR-immediate, load word, store word, branch-if-equal and jump. Any other opcode goes to an undefined step that makes no writes and then returns to fetch. All control outputs are combinational from the registered micro-address. The micro-address itself is also brought out. The datapath, register file and memory are outside the block.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, `upc_o` is 0 and every write enable is 0: `reg_write_o`, `target_write_o`, `mem_write_o`, `ir_write_o`, `pc_write_o` and `pc_write_cond_o`.
- R2: The 2-bit sequencing field of each word picks the next micro-address: 00 and 11 give 0, 01 gives the opcode table entry, and 10 gives the current address plus one.
- R3: The opcode table maps 0x00 to 2, 0x0D to 4, 0x23 to 6, 0x2B to 9, 0x04 to 11 and 0x02 to 12. Every other opcode maps to 13, a step with no control active that returns to fetch.
- R4: `alu_op_o` is 00 for add, 01 for subtract, 10 for function code and 11 for OR. It is add in fetch, decode and the load/store address steps, function code in the R-type steps, OR in the OR-immediate steps, and subtract in the branch step.
- R5: `alu_sel_b_o` is 000 for rt, 001 for the constant 4, 010 for the sign-extended immediate, 011 for the sign-extended immediate shifted left by 2, and 100 for the zero-extended immediate. `alu_sel_a_o` is 0 for PC and 1 for rs.
- R6: `pc_src_o` is 00 for the ALU result, 01 for the Target register and 10 for the jump address. Fetch writes the PC from the ALU, the branch step makes a conditional write from Target, and the jump step writes the jump address.
- R7: At address 0 (fetch), the ALU adds PC and 4, memory is read at PC (`mem_read_o`=1, `i_or_d_o`=0), and the IR and the PC are written.
- R8: At address 1 (decode), the ALU adds PC and the shifted sign-extended immediate, Target is written, and the next address comes from the opcode table.
- R9: Register writes are exclusive. `mem_to_reg_o` is 1 only in the load write-back step (address 8, rt destination). `reg_dst_o`=1 (rd) only in the R-type write-back step (address 3). The OR-immediate write-back (address 5) writes rt from the ALU.
- R10: The step sequences are: R-type 0,1,2,3; OR-immediate 0,1,4,5; load 0,1,6,7,8; store 0,1,9,10; branch 0,1,11; jump 0,1,12; undefined 0,1,13. Each sequence then returns to 0. Address 7 reads memory at the ALU address, and address 10 writes memory at the ALU address.
- R11: The opcode is used only in the decode step. Changes to the opcode in any other step have no effect on the outputs or on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Opcode of the current instruction |
| upc_o | output | 4 | Current micro-address |
| alu_op_o | output | 2 | ALU operation |
| alu_sel_a_o | output | 1 | First ALU operand select |
| alu_sel_b_o | output | 3 | Second ALU operand select |
| reg_write_o | output | 1 | Register file write enable |
| mem_to_reg_o | output | 1 | Register write data comes from memory |
| reg_dst_o | output | 1 | Register destination is rd |
| target_write_o | output | 1 | Target register write enable |
| mem_read_o | output | 1 | Memory read |
| mem_write_o | output | 1 | Memory write |
| i_or_d_o | output | 1 | Memory address is ALU output (else PC) |
| ir_write_o | output | 1 | Instruction register write enable |
| pc_write_o | output | 1 | Unconditional PC write |
| pc_write_cond_o | output | 1 | PC write if the ALU result is zero |
| pc_src_o | output | 2 | PC source select |

## Verification
The hardest case to reach from the ports is the claim that the opcode matters only in the decode step. A change to the opcode at any other time has no visible effect unless the reference model shows that the sequence ignored it. To reach this case, the bench draws a new opcode from a pool on every cycle. The pool mixes the six listed opcodes with unlisted ones. Each routine therefore runs while the opcode keeps changing under it, and the model uses only the value present at decode. Every branch of the table, including the undefined entry, is reached many times. An asynchronous reset in the middle of a routine checks that the write enables stay off while reset is held.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef struct packed {
    logic [1:0] alu;
    logic       src1;
    logic [2:0] src2;
    logic [1:0] dest;
    logic [2:0] mem;
    logic       irw;
    logic [1:0] pcw;
    logic [1:0] seq;
  } uword_t;

  localparam int UWORD_W = $bits(uword_t);

  // sequencing
  localparam logic [1:0] SQ_FETCH = 2'b00;
  localparam logic [1:0] SQ_DISP  = 2'b01;
  localparam logic [1:0] SQ_NEXT  = 2'b10;
  localparam logic [1:0] SQ_ALT   = 2'b11;

  // alu
  localparam logic [1:0] AL_ADD = 2'b00;
  localparam logic [1:0] AL_SUB = 2'b01;
  localparam logic [1:0] AL_FN  = 2'b10;
  localparam logic [1:0] AL_OR  = 2'b11;

  // operand a
  localparam logic A_PC = 1'b0;
  localparam logic A_RS = 1'b1;

  // operand b
  localparam logic [2:0] B_RT   = 3'b000;
  localparam logic [2:0] B_FOUR = 3'b001;
  localparam logic [2:0] B_SX   = 3'b010;
  localparam logic [2:0] B_SXSH = 3'b011;
  localparam logic [2:0] B_ZX   = 3'b100;

  // ALU destination
  localparam logic [1:0] D_NONE = 2'b00;
  localparam logic [1:0] D_TGT  = 2'b01;
  localparam logic [1:0] D_RD   = 2'b10;
  localparam logic [1:0] D_RT   = 2'b11;

  // memory
  localparam logic [2:0] M_NONE = 3'b000;
  localparam logic [2:0] M_RDPC = 3'b001;
  localparam logic [2:0] M_RDAL = 3'b010;
  localparam logic [2:0] M_WRAL = 3'b011;
  localparam logic [2:0] M_LDRT = 3'b100;

  // pc write control
  localparam logic [1:0] P_NONE = 2'b00;
  localparam logic [1:0] P_ALU  = 2'b01;
  localparam logic [1:0] P_COND = 2'b10;
  localparam logic [1:0] P_JMP  = 2'b11;

  // micro-addresses
  localparam int UA_FETCH = 0;
  localparam int UA_DEC   = 1;
  localparam int UA_REX   = 2;
  localparam int UA_RWB   = 3;
  localparam int UA_OEX   = 4;
  localparam int UA_OWB   = 5;
  localparam int UA_LAD   = 6;
  localparam int UA_LMEM  = 7;
  localparam int UA_LWB   = 8;
  localparam int UA_SAD   = 9;
  localparam int UA_SMEM  = 10;
  localparam int UA_BEQ   = 11;
  localparam int UA_JMP   = 12;
  localparam int UA_UNDEF = 13;

  function automatic uword_t mk_uword(
    input logic [1:0] alu, input logic src1, input logic [2:0] src2,
    input logic [1:0] dest, input logic [2:0] mem, input logic irw,
    input logic [1:0] pcw, input logic [1:0] seq);
    uword_t w;
    w.alu = alu;  w.src1 = src1; w.src2 = src2; w.dest = dest;
    w.mem = mem;  w.irw = irw;   w.pcw = pcw;   w.seq = seq;
    return w;
  endfunction

  // next micro-address from the sequencing code
  function automatic int unsigned next_uaddr(
    input int unsigned cur, input int unsigned disp, input logic [1:0] seq);
    case (seq)
      SQ_DISP: return disp;
      SQ_NEXT: return cur + 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int UPC_W = 4
) (
  input  logic [UPC_W-1:0] upc,
  output uword_t           word
);
  always_comb begin
    case (int'(upc))
      UA_FETCH: word = mk_uword(AL_ADD, A_PC, B_FOUR, D_NONE, M_RDPC, 1'b1, P_ALU,  SQ_NEXT);
      UA_DEC:   word = mk_uword(AL_ADD, A_PC, B_SXSH, D_TGT,  M_NONE, 1'b0, P_NONE, SQ_DISP);
      UA_REX:   word = mk_uword(AL_FN,  A_RS, B_RT,   D_NONE, M_NONE, 1'b0, P_NONE, SQ_NEXT);
      UA_RWB:   word = mk_uword(AL_FN,  A_RS, B_RT,   D_RD,   M_NONE, 1'b0, P_NONE, SQ_FETCH);
      UA_OEX:   word = mk_uword(AL_OR,  A_RS, B_ZX,   D_NONE, M_NONE, 1'b0, P_NONE, SQ_NEXT);
      UA_OWB:   word = mk_uword(AL_OR,  A_RS, B_ZX,   D_RT,   M_NONE, 1'b0, P_NONE, SQ_FETCH);
      UA_LAD:   word = mk_uword(AL_ADD, A_RS, B_SX,   D_NONE, M_NONE, 1'b0, P_NONE, SQ_NEXT);
      UA_LMEM:  word = mk_uword(AL_ADD, A_RS, B_SX,   D_NONE, M_RDAL, 1'b0, P_NONE, SQ_NEXT);
      UA_LWB:   word = mk_uword(AL_ADD, A_PC, B_RT,   D_NONE, M_LDRT, 1'b0, P_NONE, SQ_FETCH);
      UA_SAD:   word = mk_uword(AL_ADD, A_RS, B_SX,   D_NONE, M_NONE, 1'b0, P_NONE, SQ_NEXT);
      UA_SMEM:  word = mk_uword(AL_ADD, A_RS, B_SX,   D_NONE, M_WRAL, 1'b0, P_NONE, SQ_FETCH);
      UA_BEQ:   word = mk_uword(AL_SUB, A_RS, B_RT,   D_NONE, M_NONE, 1'b0, P_COND, SQ_FETCH);
      UA_JMP:   word = mk_uword(AL_ADD, A_PC, B_RT,   D_NONE, M_NONE, 1'b0, P_JMP,  SQ_FETCH);
      UA_UNDEF: word = mk_uword(AL_ADD, A_PC, B_RT,   D_NONE, M_NONE, 1'b0, P_NONE, SQ_FETCH);
      default:  word = mk_uword(AL_ADD, A_PC, B_RT,   D_NONE, M_NONE, 1'b0, P_NONE, SQ_ALT);
    endcase
  end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int          OPC_W   = 6,
  parameter int          UPC_W   = 4,
  parameter logic [OPC_W-1:0] OP_RTYPE = 6'h00,
  parameter logic [OPC_W-1:0] OP_ORI   = 6'h0D,
  parameter logic [OPC_W-1:0] OP_LW    = 6'h23,
  parameter logic [OPC_W-1:0] OP_SW    = 6'h2B,
  parameter logic [OPC_W-1:0] OP_BEQ   = 6'h04,
  parameter logic [OPC_W-1:0] OP_JMP   = 6'h02
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [UPC_W-1:0] entry
);
  always_comb begin
    case (opcode)
      OP_RTYPE: entry = UPC_W'(UA_REX);
      OP_ORI:   entry = UPC_W'(UA_OEX);
      OP_LW:    entry = UPC_W'(UA_LAD);
      OP_SW:    entry = UPC_W'(UA_SAD);
      OP_BEQ:   entry = UPC_W'(UA_BEQ);
      OP_JMP:   entry = UPC_W'(UA_JMP);
      default:  entry = UPC_W'(UA_UNDEF);
    endcase
  end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  uword_t     word,
  output logic [1:0] alu_op,
  output logic       sel_a,
  output logic [2:0] sel_b,
  output logic       reg_write,
  output logic       mem_to_reg,
  output logic       reg_dst,
  output logic       target_write,
  output logic       mem_read,
  output logic       mem_write,
  output logic       i_or_d,
  output logic       ir_write,
  output logic       pc_write,
  output logic       pc_write_cond,
  output logic [1:0] pc_src
);
  always_comb begin
    alu_op = word.alu;
    sel_a  = word.src1;
    sel_b  = word.src2;
    // register destination and memory-to-register share decode
    target_write = (word.dest == D_TGT);
    reg_dst      = (word.dest == D_RD);
    mem_to_reg   = (word.mem == M_LDRT);
    reg_write    = (word.dest == D_RD) || (word.dest == D_RT) || (word.mem == M_LDRT);
    mem_read     = (word.mem == M_RDPC) || (word.mem == M_RDAL);
    mem_write    = (word.mem == M_WRAL);
    i_or_d       = (word.mem == M_RDAL) || (word.mem == M_WRAL);
    ir_write     = word.irw;
    pc_write      = (word.pcw == P_ALU) || (word.pcw == P_JMP);
    pc_write_cond = (word.pcw == P_COND);
    case (word.pcw)
      P_COND:  pc_src = 2'b01;
      P_JMP:   pc_src = 2'b10;
      default: pc_src = 2'b00;
    endcase
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int UPC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode_i,
  output logic [UPC_W-1:0] upc_o,
  output logic [1:0]       alu_op_o,
  output logic             alu_sel_a_o,
  output logic [2:0]       alu_sel_b_o,
  output logic             reg_write_o,
  output logic             mem_to_reg_o,
  output logic             reg_dst_o,
  output logic             target_write_o,
  output logic             mem_read_o,
  output logic             mem_write_o,
  output logic             i_or_d_o,
  output logic             ir_write_o,
  output logic             pc_write_o,
  output logic             pc_write_cond_o,
  output logic [1:0]       pc_src_o
);
  logic [UPC_W-1:0] upc_q;
  logic [UPC_W-1:0] upc_nxt;
  logic [UPC_W-1:0] disp_addr;
  logic [1:0]       seq_code;
  uword_t           cur_word;
  logic raw_rw, raw_tw, raw_mw, raw_irw, raw_pw, raw_pwc;

  useq_store #(.UPC_W(UPC_W)) u_store (.upc(upc_q), .word(cur_word));

  useq_dispatch #(.OPC_W(OPC_W), .UPC_W(UPC_W)) u_disp (
    .opcode(opcode_i), .entry(disp_addr));

  useq_decode u_dec (
    .word(cur_word), .alu_op(alu_op_o), .sel_a(alu_sel_a_o), .sel_b(alu_sel_b_o),
    .reg_write(raw_rw), .mem_to_reg(mem_to_reg_o), .reg_dst(reg_dst_o),
    .target_write(raw_tw), .mem_read(mem_read_o), .mem_write(raw_mw),
    .i_or_d(i_or_d_o), .ir_write(raw_irw), .pc_write(raw_pw),
    .pc_write_cond(raw_pwc), .pc_src(pc_src_o));

  assign seq_code = cur_word.seq;
  assign upc_nxt  = UPC_W'(next_uaddr(int'(upc_q), int'(disp_addr), seq_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc_q <= '0;
    else        upc_q <= upc_nxt;
  end

  // write enables are held off while reset is applied
  assign reg_write_o     = raw_rw  & rst_n;
  assign target_write_o  = raw_tw  & rst_n;
  assign mem_write_o     = raw_mw  & rst_n;
  assign ir_write_o      = raw_irw & rst_n;
  assign pc_write_o      = raw_pw  & rst_n;
  assign pc_write_cond_o = raw_pwc & rst_n;
  assign upc_o           = upc_q;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int UPC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [UPC_W-1:0] upc,
  input logic [1:0]       seq_code,
  input logic [UPC_W-1:0] disp_addr,
  input logic             reg_write,
  input logic             mem_to_reg,
  input logic             reg_dst,
  input logic             target_write,
  input logic             mem_read,
  input logic             mem_write,
  input logic             i_or_d,
  input logic             ir_write,
  input logic             pc_write,
  input logic             pc_write_cond,
  input logic [1:0]       pc_src
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (upc == '0) && !reg_write && !target_write && !mem_write
               && !ir_write && !pc_write && !pc_write_cond);

  p_seq_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_code == 2'b00 || seq_code == 2'b11) |=> upc == '0);

  p_seq_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_code == 2'b10) |=> upc == UPC_W'($past(upc) + 1'b1));

  p_seq_dispatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_code == 2'b01) |=> upc == $past(disp_addr));

  p_regsrc_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_to_reg |-> reg_write && !reg_dst && !target_write);

  p_mem_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_read, mem_write}));

  p_cond_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_write_cond |-> pc_src == 2'b01 && !pc_write);

  p_fetch_ir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ir_write |-> upc == '0 && mem_read && !i_or_d);
endmodule

bind useq_ctrl useq_ctrl_chk #(.UPC_W(UPC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upc(upc_o), .seq_code(seq_code), .disp_addr(disp_addr),
  .reg_write(reg_write_o), .mem_to_reg(mem_to_reg_o), .reg_dst(reg_dst_o),
  .target_write(target_write_o), .mem_read(mem_read_o), .mem_write(mem_write_o),
  .i_or_d(i_or_d_o), .ir_write(ir_write_o), .pc_write(pc_write_o),
  .pc_write_cond(pc_write_cond_o), .pc_src(pc_src_o));

// File: tb/useq_ctrl_tb_top.sv
module useq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic [3:0] upc;
  logic [1:0] alu_op, pc_src;
  logic sel_a;
  logic [2:0] sel_b;
  logic rw, m2r, rdst, tw, mr, mw, iord, irw, pw, pwc;

  int checks = 0;
  int errors = 0;
  int m_upc = 0;
  int seen_undef = 0;
  bit done = 0;

  always #5 clk = ~clk;

  useq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .upc_o(upc),
    .alu_op_o(alu_op), .alu_sel_a_o(sel_a), .alu_sel_b_o(sel_b),
    .reg_write_o(rw), .mem_to_reg_o(m2r), .reg_dst_o(rdst),
    .target_write_o(tw), .mem_read_o(mr), .mem_write_o(mw), .i_or_d_o(iord),
    .ir_write_o(irw), .pc_write_o(pw), .pc_write_cond_o(pwc), .pc_src_o(pc_src));

  // R3 opcode table as the bench reads it
  function automatic int ref_disp(input logic [5:0] op);
    if (op == 6'h00) return 2;
    if (op == 6'h0D) return 4;
    if (op == 6'h23) return 6;
    if (op == 6'h2B) return 9;
    if (op == 6'h04) return 11;
    if (op == 6'h02) return 12;
    return 13;
  endfunction

  // R10 routines: steps that advance by one, else return to fetch
  function automatic int ref_next(input int s, input logic [5:0] op);
    if (s == 1) return ref_disp(op);
    if (s inside {0, 2, 4, 6, 7, 9}) return s + 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_upc <= 0;
    else        m_upc <= ref_next(m_upc, opcode);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at step %0d: actual %0h expected %0h", req, m_upc, act, exp);
    end
  endtask

  // expected controls per step, from R4..R10
  task automatic compare_step();
    int e_alu = 0, e_a = 0, e_b = 0, e_pcs = 0;
    bit e_rw = 0, e_m2r = 0, e_rd = 0, e_tw = 0, e_mr = 0, e_mw = 0, e_io = 0;
    bit e_ir = 0, e_pw = 0, e_pwc = 0;
    case (m_upc)
      0:  begin e_b = 1; e_mr = 1; e_ir = 1; e_pw = 1; end
      1:  begin e_b = 3; e_tw = 1; end
      2:  begin e_alu = 2; e_a = 1; end
      3:  begin e_alu = 2; e_a = 1; e_rw = 1; e_rd = 1; end
      4:  begin e_alu = 3; e_a = 1; e_b = 4; end
      5:  begin e_alu = 3; e_a = 1; e_b = 4; e_rw = 1; end
      6:  begin e_a = 1; e_b = 2; end
      7:  begin e_a = 1; e_b = 2; e_mr = 1; e_io = 1; end
      8:  begin e_rw = 1; e_m2r = 1; end
      9:  begin e_a = 1; e_b = 2; end
      10: begin e_a = 1; e_b = 2; e_mw = 1; e_io = 1; end
      11: begin e_alu = 1; e_a = 1; e_pwc = 1; e_pcs = 1; end
      12: begin e_pw = 1; e_pcs = 2; end
      default: ;
    endcase
    chk("R2/R10 upc", int'(upc), m_upc);
    chk("R4 alu_op", int'(alu_op), e_alu);
    chk("R5 operands", int'({sel_a, sel_b}), (e_a << 3) | e_b);
    chk("R6 pc ctl", int'({pw, pwc, pc_src}), (e_pw << 3) | (e_pwc << 2) | e_pcs);
    chk("R9 reg ctl", int'({rw, m2r, rdst, tw}), (e_rw << 3) | (e_m2r << 2) | (e_rd << 1) | e_tw);
    chk("R10 mem ctl", int'({mr, mw, iord, irw}), (e_mr << 3) | (e_mw << 2) | (e_io << 1) | e_ir);
    if (m_upc == 0) chk("R7 fetch reads at PC", int'({mr, iord, irw}), 3'b101);
    if (m_upc == 1) chk("R8 decode writes target", int'(tw), 1);
    if (m_upc == 13) begin
      seen_undef++;
      chk("R3 undefined entry quiet", int'({rw, tw, mw, irw, pw, pwc, mr}), 0);
    end
  endtask

  task automatic check_reset_quiet();
    chk("R1 upc in reset", int'(upc), 0);
    chk("R1 writes off in reset", int'({rw, tw, mw, irw, pw, pwc}), 0);
  endtask

  initial begin
    logic [5:0] pool [8] = '{6'h00, 6'h0D, 6'h23, 6'h2B, 6'h04, 6'h02, 6'h3F, 6'h11};
    logic [7:0] lfsr = 8'hA5;
    repeat (3) @(negedge clk);
    check_reset_quiet();
    rst_n = 1'b1;
    // R11: the opcode changes every cycle; only the decode-step value counts
    for (int cyc = 0; cyc < 1200; cyc++) begin
      @(negedge clk);
      compare_step();
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      opcode = pool[lfsr[2:0]];
      if (cyc == 600) begin
        // R1: asynchronous reset in the middle of a routine
        rst_n = 1'b0;
        #1;
        check_reset_quiet();
        @(negedge clk);
        check_reset_quiet();
        rst_n = 1'b1;
      end
    end
    chk("R3 undefined entry visited", int'(seen_undef > 0), 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule